// File: doc/BRIEF.md
# Redundant Boot Flash Chip-Select Router

This block sits between a processor's boot SPI chip selects and two physically separate SPI flash devices, so that boot firmware can live in two places. When reset is released, a boot-select switch input is sampled once. Until software says otherwise, only the processor's first chip select reaches the chosen device. The other device is kept deselected.

After the boot image has run, software writes an acknowledge bit in a control register. From that point on, each processor chip select drives its own flash device directly, so software can reach both copies. Only a reset undoes the acknowledge.

A small register port lets software read the boot state. It holds a software-owned boot-good flag, the bank the switch currently asks for, and the bank that was actually booted from. It also shows a write-protect switch as an active-low status bit.

Top module: `boot_cs_router`

## Requirements
- R1: While `rst_n` is low, and in the first clock cycle after it is released, both `flash_cs_n` bits are high whatever `cpu_cs_n` does.
- R2: At the first rising clock edge after reset release, `boot_sel_sw` is captured as the boot bank (0 selects device 0, 1 selects device 1). Before the acknowledge, the selected device's select follows `cpu_cs_n[0]` and the other device's select is held high.
- R3: Before the acknowledge, `cpu_cs_n[1]` has no effect on either `flash_cs_n` bit.
- R4: The captured boot bank, and with it the pre-acknowledge routing, does not change when `boot_sel_sw` moves after capture. It is renewed only by a reset.
- R5: A write to address 0 with bit `ACK_BIT` of `reg_wdata` set to 1 puts the block into pass-through mode, starting in the cycle after the write edge. In that mode `flash_cs_n[i]` equals `cpu_cs_n[i]` for each i.
- R6: The acknowledge is sticky until reset. A later write of 0 to address 0 does not clear it, and reading address 0 returns it in bit `ACK_BIT`, with the other bits 0.
- R7: A write to address 0 whose bit `ACK_BIT` is 0 does not acknowledge, even if every other bit is 1.
- R8: Address 1 reads the boot-good flag in bit 0, the live `boot_sel_sw` value (the priority bank) in bit 1, and the captured boot bank in bit 2. All other bits read 0.
- R9: A write to address 1 loads bit 0 of `reg_wdata` into the boot-good flag, which resets to 0. Bits 1 and 2 of address 1 cannot be written.
- R10: Address 2 bit 0 reads the inverse of `wp_sw`, so 0 means write protect is active. All other bits read 0.
- R11: Address 3 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel_sw | input | 1 | Boot bank select switch |
| wp_sw | input | 1 | Flash write-protect switch, 1 = protect |
| cpu_cs_n | input | 2 | Processor SPI chip selects, active low |
| flash_cs_n | output | 2 | Flash device chip selects, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (2) | Register address |
| reg_wdata | input | DW (8) | Register write data |
| reg_rdata | output | DW (8) | Register read data, combinational on `reg_addr` |

## Verification
The bench builds the block with `ACK_BIT` set to 2 rather than its default of 0. A decoder hard-wired to bit 0 would therefore either miss the real acknowledge or take an all-ones-except-bit-2 write as one. `AW` and `DW` stay at 2 and 8, so every address, including the unmapped one, is reachable. Resets with each switch setting bring both boot banks within reach, and the captured bank is then checked to survive a switch move.

// File: rtl/boot_cs_pkg.sv
package boot_cs_pkg;
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_BANK   = 1;
  localparam int ADDR_WPROT  = 2;
  localparam int BANK_GOOD_B = 0;
  localparam int BANK_PRIO_B = 1;
  localparam int BANK_BOOT_B = 2;
  localparam int NUM_DEV     = 2;

  // Select for one device: pass-through after ack, boot routing before.
  function automatic logic dev_select(input logic ack, input logic done,
                                      input logic bank_is_me,
                                      input logic own_cs, input logic boot_cs);
    if (ack)                    return own_cs;
    else if (done && bank_is_me) return boot_cs;
    else                        return 1'b1;
  endfunction
endpackage

// File: rtl/boot_bank_capture.sv
module boot_bank_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_sw,
  output logic done,
  output logic bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      bank <= 1'b0;
    end else if (!done) begin
      done <= 1'b1;
      bank <= sel_sw;
    end
  end
endmodule

// File: rtl/boot_cs_mux.sv
module boot_cs_mux
  import boot_cs_pkg::*;
(
  input  logic               ack,
  input  logic               done,
  input  logic               bank,
  input  logic [NUM_DEV-1:0] cpu_cs_n,
  output logic [NUM_DEV-1:0] dev_cs_n
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic mine;
    assign mine        = (bank == 1'(g));
    assign dev_cs_n[g] = dev_select(ack, done, mine, cpu_cs_n[g], cpu_cs_n[0]);
  end
endmodule

// File: rtl/boot_cs_regs.sv
module boot_cs_regs
  import boot_cs_pkg::*;
#(
  parameter int AW      = 2,
  parameter int DW      = 8,
  parameter int ACK_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          prio_sw,
  input  logic          wp_sw,
  input  logic          booted,
  output logic          ack,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL);
  localparam logic [AW-1:0] A_BANK = AW'(ADDR_BANK);
  localparam logic [AW-1:0] A_WP   = AW'(ADDR_WPROT);

  logic good;
  logic ack_wr, good_wr;

  assign ack_wr  = wr && (addr == A_CTRL) && wdata[ACK_BIT];
  assign good_wr = wr && (addr == A_BANK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack  <= 1'b0;
      good <= 1'b0;
    end else begin
      if (ack_wr)  ack  <= 1'b1;
      if (good_wr) good <= wdata[BANK_GOOD_B];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) begin
      rdata[ACK_BIT] = ack;
    end else if (addr == A_BANK) begin
      rdata[BANK_GOOD_B] = good;
      rdata[BANK_PRIO_B] = prio_sw;
      rdata[BANK_BOOT_B] = booted;
    end else if (addr == A_WP) begin
      rdata[0] = ~wp_sw;
    end
  end
endmodule

// File: rtl/boot_cs_router.sv
module boot_cs_router #(
  parameter int AW      = 2,
  parameter int DW      = 8,
  parameter int ACK_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_sel_sw,
  input  logic          wp_sw,
  input  logic [1:0]    cpu_cs_n,
  output logic [1:0]    flash_cs_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  logic cap_done;
  logic bank_q;
  logic ack_q;

  boot_bank_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_sw (boot_sel_sw),
    .done   (cap_done),
    .bank   (bank_q)
  );

  boot_cs_regs #(.AW(AW), .DW(DW), .ACK_BIT(ACK_BIT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .prio_sw (boot_sel_sw),
    .wp_sw   (wp_sw),
    .booted  (bank_q),
    .ack     (ack_q),
    .rdata   (reg_rdata)
  );

  boot_cs_mux u_mux (
    .ack      (ack_q),
    .done     (cap_done),
    .bank     (bank_q),
    .cpu_cs_n (cpu_cs_n),
    .dev_cs_n (flash_cs_n)
  );
endmodule

// File: rtl/boot_cs_router_chk.sv
module boot_cs_router_chk #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wp_sw,
  input logic [1:0]    cpu_cs_n,
  input logic [1:0]    flash_cs_n,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic          cap_done,
  input logic          bank_q,
  input logic          ack_q
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_done |-> flash_cs_n == 2'b11);

  assert_boot_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && !ack_q) |->
      (flash_cs_n[bank_q] == cpu_cs_n[0]) && flash_cs_n[!bank_q]);

  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> $stable(bank_q));

  assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> flash_cs_n == cpu_cs_n);

  assert_ack_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> ack_q);

  assert_wp_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(2)) |-> reg_rdata[0] == !wp_sw);
endmodule

bind boot_cs_router boot_cs_router_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp_sw      (wp_sw),
  .cpu_cs_n   (cpu_cs_n),
  .flash_cs_n (flash_cs_n),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .cap_done   (cap_done),
  .bank_q     (bank_q),
  .ack_q      (ack_q)
);

// File: tb/boot_cs_router_tb.sv
module boot_cs_router_tb;
  localparam int AW = 2;
  localparam int DW = 8;
  localparam int AB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          boot_sel_sw = 1'b0;
  logic          wp_sw = 1'b0;
  logic [1:0]    cpu_cs_n = 2'b11;
  logic [1:0]    flash_cs_n;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  boot_cs_router #(.AW(AW), .DW(DW), .ACK_BIT(AB)) u_dut (
    .clk(clk), .rst_n(rst_n), .boot_sel_sw(boot_sel_sw), .wp_sw(wp_sw),
    .cpu_cs_n(cpu_cs_n), .flash_cs_n(flash_cs_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {bank, cpu_cs_n[1:0], expected flash_cs_n[1:0]} before the acknowledge
  localparam logic [4:0] VEC [8] = '{
    5'b0_00_10, 5'b0_01_11, 5'b0_10_10, 5'b0_11_11,
    5'b1_00_01, 5'b1_01_11, 5'b1_10_01, 5'b1_11_11
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic bank);
    @(negedge clk);
    rst_n = 1'b0;
    boot_sel_sw = bank;
    cpu_cs_n = 2'b00;
    @(negedge clk);
    check("R1 in reset", 8'(flash_cs_n), 8'h03);
    rst_n = 1'b1;
    #1 check("R1 first cycle", 8'(flash_cs_n), 8'h03);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_check(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic cs_check(input string req, input logic [1:0] cpu, input logic [1:0] exp);
    cpu_cs_n = cpu;
    #1 check(req, 8'(flash_cs_n), 8'(exp));
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic cur_bank;
    cur_bank = 1'b0;
    repeat (2) @(negedge clk);
    do_reset(1'b0);
    reg_check("R6 reset ack clear", 2'd0, 8'h00);
    // R2 and R3: table walk, both banks
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][4] != cur_bank) begin
        cur_bank = VEC[i][4];
        do_reset(cur_bank);
      end
      cs_check($sformatf("R2/R3 vec %0d", i), VEC[i][3:2], VEC[i][1:0]);
    end
    // R8: status with bank 1 booted
    reg_check("R8 status", 2'd1, 8'h06);
    // R4: switch moves after capture
    boot_sel_sw = 1'b0;
    @(negedge clk);
    cs_check("R4 routing held", 2'b00, 2'b01);
    reg_check("R4/R8 prio live booted held", 2'd1, 8'h04);
    // R9
    reg_write(2'd1, 8'hFF);
    reg_check("R9 good set", 2'd1, 8'h05);
    reg_write(2'd1, 8'h00);
    reg_check("R9 good clear", 2'd1, 8'h04);
    // R10
    wp_sw = 1'b1;
    reg_check("R10 protect on", 2'd2, 8'h00);
    wp_sw = 1'b0;
    reg_check("R10 protect off", 2'd2, 8'h01);
    // R11
    reg_check("R11 unmapped", 2'd3, 8'h00);
    // R7
    reg_write(2'd0, 8'hFB);
    reg_check("R7 no ack", 2'd0, 8'h00);
    cs_check("R7 still boot route", 2'b10, 2'b01);
    // R5
    reg_write(2'd0, 8'h04);
    cs_check("R5 pass 10", 2'b10, 2'b10);
    cs_check("R5 pass 01", 2'b01, 2'b01);
    // R6
    reg_write(2'd0, 8'h00);
    reg_check("R6 sticky read", 2'd0, 8'h04);
    cs_check("R6 sticky route", 2'b10, 2'b10);
    // R6: reset clears acknowledge
    do_reset(1'b0);
    cs_check("R6 reset returns boot route", 2'b01, 2'b11);
    reg_check("R6 reset read", 2'd0, 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule